// File: doc/BRIEF.md
# Load Data Byte Extractor

This block sits on the load return path of a processor whose memory always delivers a full 32-bit word, even when the instruction only asks for a byte or a halfword. When the load address is issued, a strobe captures the two low address bits into a small offset register. When the data word comes back, possibly several cycles later, the block uses that stored offset to pick the wanted byte lanes. It moves them down to bit 0 and fills the upper bits with zeros or with copies of the sign bit.

Halfwords are not limited to even offsets. A halfword may start at byte 0, 1 or 2 of the word, so a halfword that spans bytes 1 and 2 is served. Only a halfword that would start at byte 3 falls off the end of the word. That case is reported on an error output instead of being served. The result and the error flag are combinational functions of the current data inputs and the stored offset. They are valid in the same cycle as the data word.

Top module: `load_extract`

## Requirements
- R1: A synchronous active-high reset clears the stored offset to 0. After reset, with no capture strobe, a byte load returns byte lane 0 (bits 7:0) whatever the value on addrLow.
- R2: The stored offset takes the value of addrLow at a rising clock edge where captureStb is 1. At every other edge it keeps its value, so loads use the offset from the last capture and not the current addrLow.
- R3: With loadSize = 2'b00 (byte) and isSigned = 0, loadData equals memWord bits [8k+7:8k], zero-extended, where k is the stored offset (0 to 3). Lanes are little-endian.
- R4: With loadSize = 2'b00 and isSigned = 1, loadData holds the same byte with bit 7 of that byte copied into bits 31:8.
- R5: With loadSize = 2'b01 (halfword), isSigned = 0 and a stored offset k of 0, 1 or 2, loadData equals memWord bits [8k+15:8k], zero-extended.
- R6: With loadSize = 2'b01, isSigned = 1 and a stored offset of 0 to 2, loadData holds the same halfword with bit 15 of that halfword copied into bits 31:16.
- R7: alignErr is 1 exactly when loadSize = 2'b01 and the stored offset is 3. In that case loadData is don't-care. alignErr is 0 for every other combination.
- R8: With loadSize = 2'b10 or 2'b11 (word), loadData equals memWord unchanged, for any stored offset and either value of isSigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| captureStb | input | 1 | Stores addrLow as the offset at this edge |
| addrLow | input | 2 | Two low bits of the computed load address |
| memWord | input | 32 | Word returned from memory |
| loadSize | input | 2 | 00 byte, 01 halfword, 10/11 word |
| isSigned | input | 1 | 1 selects sign extension, 0 selects zero fill |
| loadData | output | 32 | Right-justified, extended load result |
| alignErr | output | 1 | Halfword requested at byte offset 3 |

## Verification
The hardest case to reach is a data word that is interpreted with a stale offset while addrLow already shows something else. A design that reads addrLow directly instead of the stored offset would pass every test in which the address bits stay put. The driver therefore sets addrLow to the bitwise inverse of the captured offset on every load cycle. It also runs long series of loads with the strobe low between captures, so only the held register can give the expected lane. Each of the four offsets is captured in turn and combined with every size, both extension modes and words whose candidate sign bits differ. This covers the straddling halfword at offset 1 and the error case at offset 3.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } ldSizeT;

  typedef struct packed {
    logic [OFF_W-1:0] laneSel;
    logic             pickByte;
    logic             pickHalf;
    logic             fillSign;
  } ldxCtrlT;
endpackage

// File: rtl/ldx_ctrl.sv
module ldx_ctrl
  import ldx_pkg::*;
#(
  parameter int NLANES = LANES,
  localparam int OW = $clog2(NLANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          captureStb,
  input  logic [OW-1:0] addrLow,
  input  logic [1:0]    loadSize,
  input  logic          isSigned,
  output ldxCtrlT       ctrl,
  output logic [OW-1:0] storedOff,
  output logic          alignErr
);
  localparam logic [OW-1:0] LAST_HALF_START = OW'(NLANES - 2);

  logic [OW-1:0] offReg;
  ldSizeT        sizeDec;

  always_ff @(posedge clk) begin
    if (rst) begin
      offReg <= '0;
    end else if (captureStb) begin
      offReg <= addrLow;
    end
  end

  always_comb begin
    sizeDec       = ldSizeT'(loadSize);
    ctrl.laneSel  = offReg;
    ctrl.pickByte = (sizeDec == SZ_BYTE);
    ctrl.pickHalf = (sizeDec == SZ_HALF);
    ctrl.fillSign = isSigned;
    alignErr      = ctrl.pickHalf && (offReg > LAST_HALF_START);
  end

  assign storedOff = offReg;
endmodule

// File: rtl/ldx_datapath.sv
module ldx_datapath
  import ldx_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic [DW-1:0] memWord,
  input  ldxCtrlT       ctrl,
  output logic [DW-1:0] loadData
);
  logic [BYTE_W-1:0] laneByte [NL];
  logic [HALF_W-1:0] laneHalf [NL];
  logic [BYTE_W-1:0] byteVal;
  logic [HALF_W-1:0] halfVal;
  logic [OW-1:0]     sel;

  genvar i;
  generate
    for (i = 0; i < NL; i++) begin : g_lane
      assign laneByte[i] = memWord[BYTE_W*i +: BYTE_W];
      if (i < NL - 1) begin : g_half
        assign laneHalf[i] = memWord[BYTE_W*i +: HALF_W];
      end else begin : g_edge
        assign laneHalf[i] = {{BYTE_W{1'b0}}, memWord[BYTE_W*i +: BYTE_W]};
      end
    end
  endgenerate

  assign sel     = ctrl.laneSel;
  assign byteVal = laneByte[sel];
  assign halfVal = laneHalf[sel];

  always_comb begin
    if (ctrl.pickByte) begin
      loadData = {{(DW-BYTE_W){ctrl.fillSign & byteVal[BYTE_W-1]}}, byteVal};
    end else if (ctrl.pickHalf) begin
      loadData = {{(DW-HALF_W){ctrl.fillSign & halfVal[HALF_W-1]}}, halfVal};
    end else begin
      loadData = memWord;
    end
  end
endmodule

// File: rtl/load_extract.sv
module load_extract
  import ldx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              captureStb,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] memWord,
  input  logic [1:0]        loadSize,
  input  logic              isSigned,
  output logic [DATA_W-1:0] loadData,
  output logic              alignErr
);
  ldxCtrlT          ctrl;
  logic [OFF_W-1:0] storedOff;

  ldx_ctrl #(.NLANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .captureStb (captureStb),
    .addrLow    (addrLow),
    .loadSize   (loadSize),
    .isSigned   (isSigned),
    .ctrl       (ctrl),
    .storedOff  (storedOff),
    .alignErr   (alignErr)
  );

  ldx_datapath #(.DW(DATA_W)) u_dp (
    .memWord  (memWord),
    .ctrl     (ctrl),
    .loadData (loadData)
  );
endmodule

// File: rtl/load_extract_chk.sv
module load_extract_chk
  import ldx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              captureStb,
  input logic [OFF_W-1:0]  addrLow,
  input logic [DATA_W-1:0] memWord,
  input logic [1:0]        loadSize,
  input logic              isSigned,
  input logic [DATA_W-1:0] loadData,
  input logic              alignErr,
  input logic [OFF_W-1:0]  storedOff
);
  logic seenEdge = 1'b0;
  logic wasRst   = 1'b0;

  always_ff @(posedge clk) begin
    seenEdge <= 1'b1;
    wasRst   <= rst;
    if (seenEdge && wasRst) begin
      a_r1_reset_clears: assert (storedOff == '0)
        else $error("R1 offset not cleared by reset");
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    captureStb |=> storedOff == $past(addrLow));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !captureStb |=> $stable(storedOff));

  a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (loadSize == 2'b00 && !isSigned) |-> loadData[DATA_W-1:BYTE_W] == '0);

  a_r4_byte_sign: assert property (@(posedge clk) disable iff (rst)
    (loadSize == 2'b00 && isSigned) |->
      loadData[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){loadData[BYTE_W-1]}});

  a_r5_half_zero: assert property (@(posedge clk) disable iff (rst)
    (loadSize == 2'b01 && !isSigned && !alignErr) |-> loadData[DATA_W-1:HALF_W] == '0);

  a_r6_half_sign: assert property (@(posedge clk) disable iff (rst)
    (loadSize == 2'b01 && isSigned && !alignErr) |->
      loadData[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){loadData[HALF_W-1]}});

  a_r7_err_only_half: assert property (@(posedge clk) disable iff (rst)
    alignErr |-> loadSize == 2'b01);

  a_r8_word_pass: assert property (@(posedge clk) disable iff (rst)
    loadSize[1] |-> loadData == memWord);
endmodule

bind load_extract load_extract_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .captureStb (captureStb),
  .addrLow    (addrLow),
  .memWord    (memWord),
  .loadSize   (loadSize),
  .isSigned   (isSigned),
  .loadData   (loadData),
  .alignErr   (alignErr),
  .storedOff  (storedOff)
);

// File: tb/sim_load_extract.sv
`timescale 1ns/100ps
module sim_load_extract;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        captureStb = 1'b0;
  logic [1:0]  addrLow = 2'b00;
  logic [31:0] memWord = 32'h0;
  logic [1:0]  loadSize = 2'b00;
  logic        isSigned = 1'b0;
  logic [31:0] loadData;
  logic        alignErr;

  typedef struct {
    logic [31:0] data;
    logic        care;
    logic        err;
    string       tag;
  } expT;

  expT         sbQ[$];
  int          nChecks = 0;
  int          nFails  = 0;
  logic [1:0]  modelOff = 2'b00;
  bit          done = 1'b0;

  load_extract u0 (
    .clk(clk), .rst(rst), .captureStb(captureStb), .addrLow(addrLow),
    .memWord(memWord), .loadSize(loadSize), .isSigned(isSigned),
    .loadData(loadData), .alignErr(alignErr)
  );

  always #2.5 clk = ~clk;

  function automatic expT model(input logic [1:0] sz, input logic sg,
                                input logic [31:0] w, input logic [1:0] k,
                                input string tag);
    expT e;
    logic [31:0] sh;
    sh = w >> (8 * k);
    e.tag = tag; e.care = 1'b1; e.err = 1'b0;
    if (sz == 2'b00) begin
      e.data = {24'h0, sh[7:0]};
      if (sg && sh[7]) e.data[31:8] = 24'hFFFFFF;
    end else if (sz == 2'b01) begin
      if (k == 2'd3) begin
        e.err = 1'b1; e.care = 1'b0; e.data = 32'h0;
      end else begin
        e.data = {16'h0, sh[15:0]};
        if (sg && sh[15]) e.data[31:16] = 16'hFFFF;
      end
    end else begin
      e.data = w;
    end
    return e;
  endfunction

  task automatic capture(input logic [1:0] v);
    @(negedge clk);
    addrLow = v; captureStb = 1'b1;
    @(negedge clk);
    captureStb = 1'b0;
    modelOff = v;
    addrLow = ~v;
  endtask

  task automatic doLoad(input logic [1:0] sz, input logic sg,
                        input logic [31:0] w, input string tag);
    @(negedge clk);
    loadSize = sz; isSigned = sg; memWord = w;
    addrLow = ~modelOff;
    sbQ.push_back(model(sz, sg, w, modelOff, tag));
  endtask

  initial begin : monitor
    expT e;
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        nChecks++;
        if (alignErr !== e.err) begin
          nFails++;
          $display("FAIL %s alignErr actual %0b expected %0b", e.tag, alignErr, e.err);
        end else if (e.care && loadData !== e.data) begin
          nFails++;
          $display("FAIL %s loadData actual %h expected %h", e.tag, loadData, e.data);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [4];
    pats[0] = 32'h8F7EC312;
    pats[1] = 32'h12F48067;
    pats[2] = 32'hFF00807F;
    pats[3] = 32'h7F80017E;
    repeat (3) @(negedge clk);
    addrLow = 2'b11;
    @(negedge clk);
    rst = 1'b0;
    modelOff = 2'b00;
    // R1: reset offset is 0 though addrLow shows 3
    doLoad(2'b00, 1'b0, 32'hAABBCC9D, "R1 byte after reset");
    doLoad(2'b00, 1'b1, 32'hAABBCC9D, "R1 signed byte after reset");
    for (int k = 0; k < 4; k++) begin
      capture(2'(k));
      for (int p = 0; p < 4; p++) begin
        doLoad(2'b00, 1'b0, pats[p], "R3 byte unsigned");
        doLoad(2'b00, 1'b1, pats[p], "R4 byte signed");
        doLoad(2'b01, 1'b0, pats[p], (k == 3) ? "R7 half offset 3" : "R5 half unsigned");
        doLoad(2'b01, 1'b1, pats[p], (k == 3) ? "R7 half offset 3 signed" : "R6 half signed");
        doLoad(2'b10, 1'b1, pats[p], "R8 word");
        doLoad(2'b11, 1'b0, pats[p], "R8 wide code");
      end
    end
    // R2: held offset survives long runs with strobe low and addrLow moving
    capture(2'd1);
    for (int n = 0; n < 20; n++) begin
      doLoad(2'b01, n[0], 32'h00ABCD00 ^ (n * 32'h01010101), "R2 hold straddle");
      doLoad(2'b00, 1'b1, 32'h80808080 ^ (n << 8), "R2 hold byte");
    end
    capture(2'd2);
    capture(2'd0);
    doLoad(2'b00, 1'b0, 32'h11223344, "R2 recapture");
    doLoad(2'b01, 1'b0, 32'hDEADBEEF, "R7 no error at 0");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    modelOff = 2'b00;
    doLoad(2'b00, 1'b0, 32'hCAFEF00D, "R1 second reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule